// File: doc/BRIEF.md
# Doorbell Mailbox Register Pair

This block passes short messages between a local processor and one remote peer. Each direction has two parts. The first is a message window of `MSG_BYTES` bytes, which the sender fills with word writes, or with byte-lane writes for a tail. The second is a 32-bit doorbell word that announces the message. Both sides reach the block through their own simple register bus. A read on that bus returns its data one cycle after the request.

When a sender writes its outbound doorbell with the busy bit set, the receiver's ring status is raised, and so is its doorbell interrupt if that is unmasked. The receiver reads the message and the decoded doorbell. It then writes the inbound doorbell with busy clear. That write empties the doorbell and raises a busy-clear status, and a busy-clear interrupt if that is unmasked, back at the sender.

A sender must wait for that status before it rings again. A ring that arrives too early is dropped and recorded in a sticky overrun flag. The two directions are identical and independent.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset all doorbells, status, busy-clear status and mask bits read zero, and all four interrupt outputs are low.
- R2: Byte offsets below `MSG_BYTES` form the message window. A write goes into the sender's outbound region and honours the 4-bit byte-enable, one bit per byte lane. A read returns the same offset of the region the peer wrote.
- R3: A doorbell keeps busy (bit 31), options (bits 30:29), command (bits 19:16), protocol (bits 13:10) and length in bytes (bits 9:0). Bits 28:20 and 15:14 always read zero.
- R4: A write to the outbound doorbell (offset `MSG_BYTES`+0x00) with bit 31 set, while that doorbell is idle, stores the word. At the same clock edge it sets bit 0 of the peer's status register (offset `MSG_BYTES`+0x08). The peer reads the word at its inbound doorbell (offset `MSG_BYTES`+0x04).
- R5: The doorbell interrupt is high one cycle after status bit 0 and mask bit 0 (offset `MSG_BYTES`+0x0C) are both set, and it is low while mask bit 0 is clear.
- R6: A receiver write to its inbound doorbell with bit 31 clear, while that doorbell is busy, zeroes the doorbell and clears the receiver's status bit 0. It also sets bit 0 of the sender's busy-clear status (offset `MSG_BYTES`+0x10). The same write while the doorbell is idle has no effect.
- R7: The busy-clear interrupt is high one cycle after busy-clear status bit 0 and mask bit 11 are both set. Writing 1 to busy-clear status bit 0 clears that bit.
- R8: Status bit 1 is set while the inbound doorbell is busy and its length field exceeds `MSG_BYTES`. A length of exactly `MSG_BYTES` does not set it.
- R9: A doorbell write while the outbound doorbell is busy changes nothing on either side and sets the sticky overrun bit (status bit 4). Writing 1 to status bit 4 clears it.
- R10: An outbound doorbell write with bit 31 clear, while the doorbell is idle, stores the word without raising the peer's status or interrupt.
- R11: Traffic in one direction leaves the other direction's doorbell, status and message window unchanged.
- R12: Read data appears one cycle after the request. Unmapped offsets and accesses with address bits 1:0 non-zero read zero, and such writes are ignored. Only mask bits 0 and 11 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_req_i | input | 1 | Local bus access request |
| loc_we_i | input | 1 | Local bus write enable |
| loc_addr_i | input | ADDR_W | Local bus byte address |
| loc_be_i | input | 4 | Local byte-lane enables for message writes |
| loc_wdata_i | input | 32 | Local write data |
| loc_rdata_o | output | 32 | Local read data, one cycle after request |
| loc_irq_db_o | output | 1 | Local inbound doorbell interrupt |
| loc_irq_clr_o | output | 1 | Local outbound busy-clear interrupt |
| rmt_req_i | input | 1 | Remote bus access request |
| rmt_we_i | input | 1 | Remote bus write enable |
| rmt_addr_i | input | ADDR_W | Remote bus byte address |
| rmt_be_i | input | 4 | Remote byte-lane enables for message writes |
| rmt_wdata_i | input | 32 | Remote write data |
| rmt_rdata_o | output | 32 | Remote read data, one cycle after request |
| rmt_irq_db_o | output | 1 | Remote inbound doorbell interrupt |
| rmt_irq_clr_o | output | 1 | Remote outbound busy-clear interrupt |

## Verification
A ring status that does not follow the doorbell's busy bit shows at the receiver's status read in the cycle after the ring. It also shows on the doorbell interrupt one cycle later. A busy bit that drops without the sender's busy-clear status rising would leave the sender waiting forever. That fault shows as a missing busy-clear interrupt one cycle after the receiver's clear. A dropped ring that still alters the stored doorbell is visible at the peer's next inbound doorbell read, together with a wrong overrun flag at the sender.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DB_W     = 32;
  localparam int BUSY_B   = 31;
  localparam int LEN_W    = 10;
  // doorbell fields kept; reserved bits forced to zero
  localparam logic [DB_W-1:0] DB_KEEP = {1'b1, 2'b11, 9'h000, 4'hF, 2'b00, 4'hF, {LEN_W{1'b1}}};

  // register word index within the register area
  localparam int REG_ODB = 0;
  localparam int REG_IDB = 1;
  localparam int REG_STS = 2;
  localparam int REG_MSK = 3;
  localparam int REG_CLR = 4;

  localparam int STS_RING   = 0;
  localparam int STS_BADLEN = 1;
  localparam int STS_OVR    = 4;
  localparam int MSK_DB     = 0;
  localparam int MSK_CLR    = 11;
  localparam int CLR_DONE   = 0;

  function automatic logic [DB_W-1:0] db_clean(input logic [DB_W-1:0] v);
    return v & DB_KEEP;
  endfunction
endpackage

// File: rtl/mbx_msg_ram.sv
module mbx_msg_ram #(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [31:0]   rdata_o
);
  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) lane_mem[widx_i] <= wdata_i[8*b +: 8];
      rdata_o[8*b +: 8] <= lane_mem[ridx_i];
    end
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            msg_we_i,
  input  logic [IW-1:0]   msg_idx_i,
  input  logic [3:0]      msg_be_i,
  input  logic [31:0]     msg_wdata_i,
  input  logic            db_we_i,
  input  logic [DB_W-1:0] db_wdata_i,
  input  logic            db_clr_req_i,
  input  logic [IW-1:0]   rd_idx_i,
  output logic [31:0]     rd_data_o,
  output logic [DB_W-1:0] db_o,
  output logic            ring_o,
  output logic            clr_o,
  output logic            drop_o
);
  logic [DB_W-1:0] db_q;
  logic busy, accept;

  assign busy   = db_q[BUSY_B];
  assign accept = db_we_i && !busy;
  assign drop_o = db_we_i && busy;
  assign clr_o  = db_clr_req_i && busy;
  assign ring_o = accept && db_wdata_i[BUSY_B];
  assign db_o   = db_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     db_q <= '0;
    else if (clr_o)  db_q <= '0;
    else if (accept) db_q <= db_clean(db_wdata_i);
  end

  mbx_msg_ram #(.WORDS(WORDS)) u_ram (
    .clk_i  (clk_i),
    .we_i   (msg_we_i),
    .widx_i (msg_idx_i),
    .be_i   (msg_be_i),
    .wdata_i(msg_wdata_i),
    .ridx_i (rd_idx_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int MSG_BYTES = 128,
  localparam int ADDR_W = $clog2(MSG_BYTES) + 1,
  localparam int IW = ADDR_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [DB_W-1:0]   out_db_i,
  input  logic [DB_W-1:0]   in_db_i,
  input  logic [31:0]       in_ram_i,
  input  logic              ring_in_i,
  input  logic              clr_in_i,
  input  logic              clr_out_i,
  input  logic              drop_out_i,
  output logic              msg_we_o,
  output logic              odb_we_o,
  output logic              idb_clr_o,
  output logic [IW-1:0]     idx_o,
  output logic              st_ring_o,
  output logic              clr_st_o,
  output logic              irq_db_o,
  output logic              irq_clr_o
);
  logic aligned, in_reg, wr, rd;
  logic st_ring_q, st_ovr_q, msk_db_q, msk_clr_q, clr_st_q, badlen;
  logic wr_sts, wr_msk, wr_clr;
  logic sel_ram_q;
  logic [31:0] reg_rd_q, reg_val;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_reg  = addr_i[ADDR_W-1];
  assign idx_o   = addr_i[ADDR_W-2:2];
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i;

  assign msg_we_o  = wr && !in_reg;
  assign odb_we_o  = wr && in_reg && (idx_o == IW'(REG_ODB));
  assign idb_clr_o = wr && in_reg && (idx_o == IW'(REG_IDB)) && !wdata_i[BUSY_B];
  assign wr_sts    = wr && in_reg && (idx_o == IW'(REG_STS));
  assign wr_msk    = wr && in_reg && (idx_o == IW'(REG_MSK));
  assign wr_clr    = wr && in_reg && (idx_o == IW'(REG_CLR));

  assign badlen = in_db_i[BUSY_B] && (in_db_i[LEN_W-1:0] > LEN_W'(MSG_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_ring_q <= 1'b0;
      st_ovr_q  <= 1'b0;
      msk_db_q  <= 1'b0;
      msk_clr_q <= 1'b0;
      clr_st_q  <= 1'b0;
    end else begin
      if (ring_in_i)     st_ring_q <= 1'b1;
      else if (clr_in_i) st_ring_q <= 1'b0;
      if (drop_out_i)                     st_ovr_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_OVR]) st_ovr_q <= 1'b0;
      if (wr_msk) begin
        msk_db_q  <= wdata_i[MSK_DB];
        msk_clr_q <= wdata_i[MSK_CLR];
      end
      // a new busy-clear event wins over a same-cycle acknowledge
      if (clr_out_i)                        clr_st_q <= 1'b1;
      else if (wr_clr && wdata_i[CLR_DONE]) clr_st_q <= 1'b0;
    end
  end

  always_comb begin
    reg_val = '0;
    if (aligned && in_reg) begin
      case (idx_o)
        IW'(REG_ODB): reg_val = out_db_i;
        IW'(REG_IDB): reg_val = in_db_i;
        IW'(REG_STS): begin
          reg_val[STS_RING]   = st_ring_q;
          reg_val[STS_BADLEN] = badlen;
          reg_val[STS_OVR]    = st_ovr_q;
        end
        IW'(REG_MSK): begin
          reg_val[MSK_DB]  = msk_db_q;
          reg_val[MSK_CLR] = msk_clr_q;
        end
        IW'(REG_CLR): reg_val[CLR_DONE] = clr_st_q;
        default: reg_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rd_q  <= '0;
      sel_ram_q <= 1'b0;
      irq_db_o  <= 1'b0;
      irq_clr_o <= 1'b0;
    end else begin
      if (rd) begin
        reg_rd_q  <= reg_val;
        sel_ram_q <= aligned && !in_reg;
      end
      irq_db_o  <= st_ring_q && msk_db_q;
      irq_clr_o <= clr_st_q && msk_clr_q;
    end
  end

  assign rdata_o   = sel_ram_q ? in_ram_i : reg_rd_q;
  assign st_ring_o = st_ring_q;
  assign clr_st_o  = clr_st_q;
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int MSG_BYTES = 128,
  localparam int ADDR_W = $clog2(MSG_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loc_req_i,
  input  logic              loc_we_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [3:0]        loc_be_i,
  input  logic [31:0]       loc_wdata_i,
  output logic [31:0]       loc_rdata_o,
  output logic              loc_irq_db_o,
  output logic              loc_irq_clr_o,
  input  logic              rmt_req_i,
  input  logic              rmt_we_i,
  input  logic [ADDR_W-1:0] rmt_addr_i,
  input  logic [3:0]        rmt_be_i,
  input  logic [31:0]       rmt_wdata_i,
  output logic [31:0]       rmt_rdata_o,
  output logic              rmt_irq_db_o,
  output logic              rmt_irq_clr_o
);
  localparam int WORDS = MSG_BYTES / 4;
  localparam int IW    = $clog2(WORDS);

  // index 0: local side / local-to-remote channel; index 1: remote
  logic              b_req   [2];
  logic              b_we    [2];
  logic [ADDR_W-1:0] b_addr  [2];
  logic [3:0]        b_be    [2];
  logic [31:0]       b_wdata [2];
  logic [31:0]       b_rdata [2];
  logic              irq_db  [2];
  logic              irq_clr [2];

  logic [DB_W-1:0] db      [2];
  logic [31:0]     ram_rd  [2];
  logic            ring    [2];
  logic            clr     [2];
  logic            drop    [2];
  logic            msg_we  [2];
  logic            odb_we  [2];
  logic            idb_clr [2];
  logic [IW-1:0]   idx     [2];
  logic            st_ring [2];
  logic            clr_st  [2];

  assign b_req[0]   = loc_req_i;   assign b_req[1]   = rmt_req_i;
  assign b_we[0]    = loc_we_i;    assign b_we[1]    = rmt_we_i;
  assign b_addr[0]  = loc_addr_i;  assign b_addr[1]  = rmt_addr_i;
  assign b_be[0]    = loc_be_i;    assign b_be[1]    = rmt_be_i;
  assign b_wdata[0] = loc_wdata_i; assign b_wdata[1] = rmt_wdata_i;
  assign loc_rdata_o   = b_rdata[0]; assign rmt_rdata_o   = b_rdata[1];
  assign loc_irq_db_o  = irq_db[0];  assign rmt_irq_db_o  = irq_db[1];
  assign loc_irq_clr_o = irq_clr[0]; assign rmt_irq_clr_o = irq_clr[1];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    mbx_channel #(.WORDS(WORDS)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .msg_we_i    (msg_we[c]),
      .msg_idx_i   (idx[c]),
      .msg_be_i    (b_be[c]),
      .msg_wdata_i (b_wdata[c]),
      .db_we_i     (odb_we[c]),
      .db_wdata_i  (b_wdata[c]),
      .db_clr_req_i(idb_clr[1-c]),
      .rd_idx_i    (idx[1-c]),
      .rd_data_o   (ram_rd[c]),
      .db_o        (db[c]),
      .ring_o      (ring[c]),
      .clr_o       (clr[c]),
      .drop_o      (drop[c])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    mbx_side #(.MSG_BYTES(MSG_BYTES)) u_side (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (b_req[s]),
      .we_i      (b_we[s]),
      .addr_i    (b_addr[s]),
      .wdata_i   (b_wdata[s]),
      .rdata_o   (b_rdata[s]),
      .out_db_i  (db[s]),
      .in_db_i   (db[1-s]),
      .in_ram_i  (ram_rd[1-s]),
      .ring_in_i (ring[1-s]),
      .clr_in_i  (clr[1-s]),
      .clr_out_i (clr[s]),
      .drop_out_i(drop[s]),
      .msg_we_o  (msg_we[s]),
      .odb_we_o  (odb_we[s]),
      .idb_clr_o (idb_clr[s]),
      .idx_o     (idx[s]),
      .st_ring_o (st_ring[s]),
      .clr_st_o  (clr_st[s]),
      .irq_db_o  (irq_db[s]),
      .irq_clr_o (irq_clr[s])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DB_W-1:0] db_i      [2],
  input logic            clr_i     [2],
  input logic            st_ring_i [2],
  input logic            clr_st_i  [2],
  input logic            irq_clr_i [2]
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R4: receiver ring status implies the channel doorbell is busy
    a_r4_ring_has_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_ring_i[1-c] |-> db_i[c][BUSY_B]);
    // R6: busy can only drop together with a busy-clear status at the sender
    a_r6_drop_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(db_i[c][BUSY_B]) |-> clr_st_i[c]);
    // R9: a busy doorbell changes only through a clear
    a_r9_busy_db_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(db_i[c][BUSY_B]) && !$past(clr_i[c])) |-> $stable(db_i[c]));
    // R3: reserved doorbell bits stay zero
    a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (db_i[c] & ~DB_KEEP) == '0);
    // R7: busy-clear interrupt rises only after its status was set
    a_r7_irq_clr_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_clr_i[c]) |-> $past(clr_st_i[c]));
  end
endmodule

bind doorbell_mailbox mbx_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .db_i     (db),
  .clr_i    (clr),
  .st_ring_i(st_ring),
  .clr_st_i (clr_st),
  .irq_clr_i(irq_clr)
);

// File: tb/sim_doorbell_mailbox.sv
`timescale 1ns/1ps
module sim_doorbell_mailbox;
  localparam int AW = 8;
  localparam logic [7:0] ODB = 8'h80, IDB = 8'h84, STS = 8'h88, MSK = 8'h8C, CLR = 8'h90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          b_req   [2];
  logic          b_we    [2];
  logic [AW-1:0] b_addr  [2];
  logic [3:0]    b_be    [2];
  logic [31:0]   b_wdata [2];
  logic [31:0] loc_rdata, rmt_rdata;
  logic loc_irq_db, loc_irq_clr, rmt_irq_db, rmt_irq_clr;

  doorbell_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .loc_req_i(b_req[0]), .loc_we_i(b_we[0]), .loc_addr_i(b_addr[0]),
    .loc_be_i(b_be[0]), .loc_wdata_i(b_wdata[0]), .loc_rdata_o(loc_rdata),
    .loc_irq_db_o(loc_irq_db), .loc_irq_clr_o(loc_irq_clr),
    .rmt_req_i(b_req[1]), .rmt_we_i(b_we[1]), .rmt_addr_i(b_addr[1]),
    .rmt_be_i(b_be[1]), .rmt_wdata_i(b_wdata[1]), .rmt_rdata_o(rmt_rdata),
    .rmt_irq_db_o(rmt_irq_db), .rmt_irq_clr_o(rmt_irq_clr)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q [$];
  int          side_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  // monitor: compare read data one cycle after each read request
  always @(posedge clk) rd_seen <= (b_req[0] && !b_we[0]) || (b_req[1] && !b_we[1]);
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e, a;
      int s;
      string t;
      e = exp_q.pop_front(); s = side_q.pop_front(); t = tag_q.pop_front();
      a = (s == 0) ? loc_rdata : rmt_rdata;
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic bus(input int s, input bit we, input logic [7:0] a,
                     input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    b_req[s] = 1'b1; b_we[s] = we; b_addr[s] = a; b_be[s] = be; b_wdata[s] = d;
    @(negedge clk);
    b_req[s] = 1'b0; b_we[s] = 1'b0;
  endtask

  task automatic wr(input int s, input logic [7:0] a, input logic [31:0] d);
    bus(s, 1'b1, a, 4'hF, d);
  endtask

  task automatic rd(input int s, input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); side_q.push_back(s); tag_q.push_back(t);
    bus(s, 1'b0, a, 4'h0, 32'h0);
  endtask

  task automatic chk(input logic a, input logic e, input string t);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", t, a, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      b_req[s] = 1'b0; b_we[s] = 1'b0; b_addr[s] = '0; b_be[s] = '0; b_wdata[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(loc_irq_db, 1'b0, "R1 loc irq_db"); chk(loc_irq_clr, 1'b0, "R1 loc irq_clr");
    chk(rmt_irq_db, 1'b0, "R1 rmt irq_db"); chk(rmt_irq_clr, 1'b0, "R1 rmt irq_clr");
    rd(0, ODB, 32'h0, "R1 loc odb"); rd(0, IDB, 32'h0, "R1 loc idb");
    rd(0, STS, 32'h0, "R1 loc sts"); rd(0, MSK, 32'h0, "R1 loc msk");
    rd(0, CLR, 32'h0, "R1 loc clr"); rd(1, STS, 32'h0, "R1 rmt sts");

    // R2 message window: word and byte-lane writes
    wr(0, 8'h00, 32'hA1B2C3D4); wr(0, 8'h04, 32'h11223344); wr(0, 8'h08, 32'h55667788);
    bus(0, 1'b1, 8'h08, 4'b0100, 32'h00EE0000);
    rd(1, 8'h00, 32'hA1B2C3D4, "R2 word0"); rd(1, 8'h04, 32'h11223344, "R2 word1");
    rd(1, 8'h08, 32'h55EE7788, "R2 byte lane");

    // R12 mask keeps only bits 0 and 11
    wr(1, MSK, 32'hFFFFFFFF); rd(1, MSK, 32'h00000801, "R12 mask bits");
    wr(1, MSK, 32'h00000001);

    // R3 R4 R5 R8 ring with all ones
    wr(0, ODB, 32'hFFFFFFFF);
    chk(rmt_irq_db, 1'b0, "R5 irq one cycle after status");
    @(negedge clk);
    chk(rmt_irq_db, 1'b1, "R5 irq asserted");
    rd(1, IDB, 32'hE00F3FFF, "R3 field decode inbound");
    rd(0, ODB, 32'hE00F3FFF, "R3 field decode outbound");
    rd(1, STS, 32'h00000003, "R4 R8 ring and bad length");

    // R9 ring while busy is dropped
    wr(0, ODB, 32'h80000010);
    rd(1, IDB, 32'hE00F3FFF, "R9 doorbell unchanged");
    rd(1, STS, 32'h00000003, "R9 peer status unchanged");
    rd(0, STS, 32'h00000010, "R9 overrun set");
    wr(0, STS, 32'h00000010); rd(0, STS, 32'h0, "R9 overrun cleared");

    // R6 R7 receiver clears
    wr(1, IDB, 32'h0);
    rd(1, IDB, 32'h0, "R6 doorbell zeroed");
    rd(1, STS, 32'h0, "R6 ring status cleared");
    rd(0, CLR, 32'h1, "R6 busy-clear status");
    chk(loc_irq_clr, 1'b0, "R7 masked busy-clear irq");
    chk(rmt_irq_db, 1'b0, "R5 irq drops after clear");
    wr(0, MSK, 32'h00000800);
    @(negedge clk);
    chk(loc_irq_clr, 1'b1, "R7 busy-clear irq");
    wr(0, CLR, 32'h1);
    @(negedge clk);
    chk(loc_irq_clr, 1'b0, "R7 irq after acknowledge");
    rd(0, CLR, 32'h0, "R7 status acknowledged");

    // R8 boundary and R5 masking
    wr(1, MSK, 32'h0);
    wr(0, ODB, 32'h80000080);
    rd(1, STS, 32'h00000001, "R8 length equal to region");
    chk(rmt_irq_db, 1'b0, "R5 masked doorbell irq");
    wr(1, MSK, 32'h1);
    @(negedge clk);
    chk(rmt_irq_db, 1'b1, "R5 unmask raises irq");
    wr(1, IDB, 32'h0);
    wr(0, ODB, 32'h80000081);
    rd(1, STS, 32'h00000003, "R8 length one over region");
    wr(1, IDB, 32'h0);

    // R10 store without ring; R6 idle clear ignored
    wr(0, CLR, 32'h1);
    wr(0, ODB, 32'h00000005);
    rd(0, ODB, 32'h00000005, "R10 stored");
    rd(1, STS, 32'h0, "R10 no ring");
    chk(rmt_irq_db, 1'b0, "R10 no irq");
    wr(1, IDB, 32'h0);
    rd(1, IDB, 32'h00000005, "R6 idle clear ignored");
    rd(0, CLR, 32'h0, "R6 idle clear no status");

    // R11 reverse direction
    wr(0, MSK, 32'h00000801);
    wr(1, 8'h10, 32'hCAFEF00D);
    wr(1, ODB, 32'h80010404);
    @(negedge clk);
    chk(loc_irq_db, 1'b1, "R11 reverse irq");
    rd(0, IDB, 32'h80010404, "R11 reverse doorbell");
    rd(0, STS, 32'h00000001, "R11 reverse status");
    rd(0, 8'h10, 32'hCAFEF00D, "R11 reverse message");
    rd(1, STS, 32'h0, "R11 other direction status");
    rd(0, ODB, 32'h00000005, "R11 other direction doorbell");
    rd(1, 8'h00, 32'hA1B2C3D4, "R11 other direction message");

    // R12 unmapped and misaligned
    rd(0, 8'hFC, 32'h0, "R12 unmapped");
    rd(1, 8'h81, 32'h0, "R12 misaligned read");
    wr(1, 8'h8D, 32'h0);
    rd(1, MSK, 32'h1, "R12 misaligned write ignored");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule